// File: doc/BRIEF.md
# Predicated Branch Delay-Slot Controller

This block sits in the issue stage of a three-lane statically scheduled front end in which every branch is followed by a fixed number of delay-slot bundles. Those bundles always issue, whatever the branch outcome. Each instruction in them carries a two-bit guard tied to the condition of the branch that opened the window. The compiler can therefore hoist work from both the taken target and the fall-through path into the slots. Only the work that belongs to the path actually followed is kept.

Each cycle the controller receives the issued bundle: a valid bit, per-lane valid and branch markers, per-lane guard fields, the branch condition and the branch target. It returns one commit enable per lane, the fetch address of the bundle now issuing, and the address of the next bundle. The branch condition and target are captured when the branch issues. The guards of the following bundles are resolved against that captured value in the cycle those bundles issue. The redirect to the target takes effect only after the last delay-slot bundle. A branch that appears inside an open window is illegal and is flagged. A bundle that carries more than one branch is also illegal and is flagged.

Top module: `bds_delay_slot_ctrl`

## Requirements
- R1: While reset is low, and on the first edge after it, fetch_pc equals RESET_PC (0x100 by default) and no delay window is open.
- R2: Outside a delay window, every valid lane of a valid bundle commits and its guard field has no effect. A bundle with issue_valid low commits no lane.
- R3: In a delay-slot bundle, a valid lane whose guard is 2'b00 commits.
- R4: In a delay-slot bundle, a valid lane whose guard is 2'b01 commits only if the condition captured at the branch was 1.
- R5: In a delay-slot bundle, a valid lane whose guard is 2'b10 commits only if the captured condition was 0.
- R6: In a delay-slot bundle, a lane whose guard is 2'b11 never commits. A squashed lane's commit enable is low in the same cycle its bundle issues.
- R7: A branch opens a window covering exactly the next SLOTS (3) valid bundles. Cycles with issue_valid low do not consume a slot, and in_delay_slot stays high across them.
- R8: next_pc is fetch_pc + 12 for a valid bundle, and fetch_pc for an idle cycle. On the last slot bundle of a window whose captured condition is 1, it is the captured target. fetch_pc takes next_pc at the clock edge.
- R9: A branch marker on a valid lane of a slot bundle raises nest_err in that cycle. It does not change the open window, the captured condition or the captured target.
- R10: A bundle with more than one valid branch marker raises nest_err. The window it opens uses that bundle's branch_cond and branch_target.
- R11: A branch marker on a lane whose lane_valid bit is low, or in a bundle with issue_valid low, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | A bundle issues this cycle |
| lane_valid | input | 3 | Per-lane instruction present |
| lane_is_branch | input | 3 | Per-lane branch marker |
| lane_guard | input | 6 | Two guard bits per lane, lane i at [2i+1:2i] |
| branch_cond | input | 1 | Evaluated condition of the branch in this bundle |
| branch_target | input | 32 | Target address of the branch in this bundle |
| commit_en | output | 3 | Per-lane commit enable |
| fetch_pc | output | 32 | Address of the bundle now issuing |
| next_pc | output | 32 | Address of the following bundle |
| in_delay_slot | output | 1 | A delay window is open this cycle |
| nest_err | output | 1 | Illegal branch placement in this bundle |

## Verification
The hardest situation to reach is a nested branch whose own condition and target differ from those of the open window. Only then can an error of capture or restart show up at the ports. The stimulus opens a window with a false condition and places a branch with a true condition and a different target in the second slot. It then checks, in the last slot, that true-guarded work is still squashed and that the fall-through address follows. A bubble placed inside a window and a reset inside a window exercise the slot count and the clearing of captured state.

// File: rtl/bds_pkg.sv
// Shared types for the delay-slot controller.
// Assumes guard fields are two bits wide; the encoding is fixed by R3..R6.
package bds_pkg;
    typedef enum logic [1:0] {
        GUARD_ALWAYS   = 2'b00,
        GUARD_IF_TRUE  = 2'b01,
        GUARD_IF_FALSE = 2'b10,
        GUARD_NEVER    = 2'b11
    } guard_e;

    localparam int GUARD_W = 2;
endpackage

// File: rtl/bds_guard_eval.sv
// Per-lane commit decision.
// Outside a window, any valid lane commits. Inside one, the guard is compared
// with the captured branch condition. Purely combinational, so a squash is
// visible in the cycle the lane issues.
module bds_guard_eval
    import bds_pkg::*;
(
    input  logic               issue_valid,
    input  logic               lane_valid,
    input  logic               in_window,
    input  logic               cond_q,
    input  logic [GUARD_W-1:0] guard,
    output logic               commit
);
    guard_e g;
    logic   pass;

    // Decode the guard against the captured condition.
    always_comb begin
        g = guard_e'(guard);
        unique case (g)
            GUARD_ALWAYS:   pass = 1'b1;
            GUARD_IF_TRUE:  pass = cond_q;
            GUARD_IF_FALSE: pass = !cond_q;
            default:        pass = 1'b0;
        endcase
    end

    // Combine lane presence with the window-qualified guard result.
    always_comb begin
        commit = issue_valid && lane_valid && (!in_window || pass);
    end
endmodule

// File: rtl/bds_branch_pick.sv
// Finds valid branch markers in the issuing bundle.
// Assumes only markers on valid lanes of a valid bundle count.
module bds_branch_pick #(
    parameter int LANES = 3
) (
    input  logic             issue_valid,
    input  logic [LANES-1:0] lane_valid,
    input  logic [LANES-1:0] lane_is_branch,
    output logic             br_found,
    output logic             br_multi
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [LANES-1:0] live;
    logic [CNT_W-1:0] n_br;

    // Mask markers by lane and bundle validity.
    always_comb begin
        live = issue_valid ? (lane_valid & lane_is_branch) : '0;
    end

    // Count live markers to spot both presence and duplicates.
    always_comb begin
        n_br = '0;
        for (int i = 0; i < LANES; i++) begin
            n_br = n_br + CNT_W'(live[i]);
        end
        br_found = (n_br != '0);
        br_multi = (n_br > CNT_W'(1));
    end
endmodule

// File: rtl/bds_slot_tracker.sv
// Delay-window state: remaining slot bundles, and the condition and target
// captured from the opening branch.
// Assumes open is asserted only when no window is active and a bundle issues.
// Idle cycles do not consume a slot.
module bds_slot_tracker #(
    parameter int SLOTS = 3,
    parameter int PC_W  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            open,
    input  logic            cond_in,
    input  logic [PC_W-1:0] target_in,
    output logic            in_window,
    output logic            last_slot,
    output logic            cond_q,
    output logic [PC_W-1:0] target_q
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] remain_q;

    // Load the slot count on open; count down on each issuing slot bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (open) begin
            remain_q <= CNT_W'(SLOTS);
        end else if (issue_valid && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Capture the branch outcome and target only when a window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q   <= 1'b0;
            target_q <= '0;
        end else if (open) begin
            cond_q   <= cond_in;
            target_q <= target_in;
        end
    end

    // Window flags derived from the remaining count.
    always_comb begin
        in_window = (remain_q != '0);
        last_slot = (remain_q == CNT_W'(1));
    end
endmodule

// File: rtl/bds_pc_seq.sv
// Fetch address register and next-address selection.
// Assumes redirect is only asserted together with issue_valid.
module bds_pc_seq #(
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] RESET_PC     = 32'h100,
    parameter int              BUNDLE_BYTES = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(BUNDLE_BYTES);

    // Select hold, redirect or sequential step.
    always_comb begin
        if (!issue_valid)  next_pc = fetch_pc;
        else if (redirect) next_pc = target;
        else               next_pc = fetch_pc + STEP;
    end

    // Advance the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_pc <= RESET_PC;
        else        fetch_pc <= next_pc;
    end
endmodule

// File: rtl/bds_delay_slot_ctrl.sv
// Top of the predicated delay-slot controller.
// Assumes one branch condition and target per bundle, a window of SLOTS
// bundles, and guards resolved against the condition captured at the branch.
module bds_delay_slot_ctrl
    import bds_pkg::*;
#(
    parameter int              LANES      = 3,
    parameter int              SLOTS      = 3,
    parameter int              PC_W       = 32,
    parameter int              INSTR_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = 32'h100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [LANES-1:0]         lane_valid,
    input  logic [LANES-1:0]         lane_is_branch,
    input  logic [LANES*GUARD_W-1:0] lane_guard,
    input  logic                     branch_cond,
    input  logic [PC_W-1:0]          branch_target,
    output logic [LANES-1:0]         commit_en,
    output logic [PC_W-1:0]          fetch_pc,
    output logic [PC_W-1:0]          next_pc,
    output logic                     in_delay_slot,
    output logic                     nest_err
);
    localparam int BUNDLE_BYTES = LANES * INSTR_BYTES;

    logic            br_found;
    logic            br_multi;
    logic            open;
    logic            last_slot;
    logic            cond_q;
    logic [PC_W-1:0] target_q;
    logic            redirect;

    bds_branch_pick #(.LANES(LANES)) u_pick (
        .issue_valid    (issue_valid),
        .lane_valid     (lane_valid),
        .lane_is_branch (lane_is_branch),
        .br_found       (br_found),
        .br_multi       (br_multi)
    );

    // A legal branch opens a window; one inside a window does not.
    always_comb begin
        open     = br_found && !in_delay_slot;
        nest_err = (br_found && in_delay_slot) || br_multi;
        redirect = issue_valid && last_slot && cond_q;
    end

    bds_slot_tracker #(.SLOTS(SLOTS), .PC_W(PC_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .open        (open),
        .cond_in     (branch_cond),
        .target_in   (branch_target),
        .in_window   (in_delay_slot),
        .last_slot   (last_slot),
        .cond_q      (cond_q),
        .target_q    (target_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bds_guard_eval u_eval (
            .issue_valid (issue_valid),
            .lane_valid  (lane_valid[i]),
            .in_window   (in_delay_slot),
            .cond_q      (cond_q),
            .guard       (lane_guard[i*GUARD_W +: GUARD_W]),
            .commit      (commit_en[i])
        );
    end

    bds_pc_seq #(
        .PC_W         (PC_W),
        .RESET_PC     (RESET_PC),
        .BUNDLE_BYTES (BUNDLE_BYTES)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .redirect    (redirect),
        .target      (target_q),
        .fetch_pc    (fetch_pc),
        .next_pc     (next_pc)
    );
endmodule

// File: rtl/bds_delay_slot_chk.sv
// Port-level properties of the delay-slot controller, bound to the top.
module bds_delay_slot_chk
    import bds_pkg::*;
#(
    parameter int              LANES    = 3,
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = 32'h100
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue_valid,
    input logic [LANES-1:0]         lane_valid,
    input logic [LANES-1:0]         lane_is_branch,
    input logic [LANES*GUARD_W-1:0] lane_guard,
    input logic [LANES-1:0]         commit_en,
    input logic [PC_W-1:0]          fetch_pc,
    input logic [PC_W-1:0]          next_pc,
    input logic                     in_delay_slot,
    input logic                     nest_err
);
    // R1
    reset_pc_chk: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc == RESET_PC && !in_delay_slot));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> next_pc == fetch_pc);

    // R8
    pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fetch_pc == $past(next_pc));

    // R9
    nest_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_delay_slot && issue_valid && |(lane_valid & lane_is_branch)) |-> nest_err);

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R6
        guard_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_delay_slot && lane_guard[i*GUARD_W +: GUARD_W] == 2'b11) |-> !commit_en[i]);

        // R2
        open_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_delay_slot && issue_valid && lane_valid[i]) |-> commit_en[i]);

        // R2
        no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit_en[i] |-> (issue_valid && lane_valid[i]));
    end
endmodule

bind bds_delay_slot_ctrl bds_delay_slot_chk #(
    .LANES    (LANES),
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_valid    (issue_valid),
    .lane_valid     (lane_valid),
    .lane_is_branch (lane_is_branch),
    .lane_guard     (lane_guard),
    .commit_en      (commit_en),
    .fetch_pc       (fetch_pc),
    .next_pc        (next_pc),
    .in_delay_slot  (in_delay_slot),
    .nest_err       (nest_err)
);

// File: tb/tb_bds_delay_slot_ctrl.sv
module tb_bds_delay_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [2:0]  lane_valid;
    logic [2:0]  lane_is_branch;
    logic [5:0]  lane_guard;
    logic        branch_cond;
    logic [31:0] branch_target;
    logic [2:0]  commit_en;
    logic [31:0] fetch_pc;
    logic [31:0] next_pc;
    logic        in_delay_slot;
    logic        nest_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bds_delay_slot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .lane_valid(lane_valid), .lane_is_branch(lane_is_branch),
        .lane_guard(lane_guard), .branch_cond(branch_cond),
        .branch_target(branch_target), .commit_en(commit_en),
        .fetch_pc(fetch_pc), .next_pc(next_pc),
        .in_delay_slot(in_delay_slot), .nest_err(nest_err)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        vld;
        logic [2:0]  lv;
        logic [2:0]  br;
        logic [5:0]  grd;
        logic        cnd;
        logic [31:0] tgt;
        logic [2:0]  x_commit;
        logic [31:0] x_pc;
        logic [31:0] x_npc;
        logic        x_slot;
        logic        x_err;
    } vec_t;

    // Guard field: {lane2, lane1, lane0}.
    localparam vec_t VECS [17] = '{
        '{4'd2,  1'b1, 3'b111, 3'b000, 6'b111111, 1'b0, 32'h0,   3'b111, 32'h100, 32'h10C, 1'b0, 1'b0}, // R2 guards ignored
        '{4'd8,  1'b1, 3'b111, 3'b001, 6'b111111, 1'b1, 32'h400, 3'b111, 32'h10C, 32'h118, 1'b0, 1'b0}, // R8 branch, taken
        '{4'd4,  1'b1, 3'b111, 3'b000, 6'b100100, 1'b0, 32'h0,   3'b011, 32'h118, 32'h124, 1'b1, 1'b0}, // R3 R4 R5 slot 1
        '{4'd7,  1'b0, 3'b111, 3'b000, 6'b000000, 1'b0, 32'h0,   3'b000, 32'h124, 32'h124, 1'b1, 1'b0}, // R7 bubble
        '{4'd6,  1'b1, 3'b111, 3'b000, 6'b111001, 1'b0, 32'h0,   3'b001, 32'h124, 32'h130, 1'b1, 1'b0}, // R6 slot 2
        '{4'd8,  1'b1, 3'b101, 3'b000, 6'b000000, 1'b0, 32'h0,   3'b101, 32'h130, 32'h400, 1'b1, 1'b0}, // R8 redirect
        '{4'd7,  1'b1, 3'b111, 3'b000, 6'b101010, 1'b0, 32'h0,   3'b111, 32'h400, 32'h40C, 1'b0, 1'b0}, // R7 window closed
        '{4'd8,  1'b1, 3'b111, 3'b100, 6'b000000, 1'b0, 32'h800, 3'b111, 32'h40C, 32'h418, 1'b0, 1'b0}, // R8 not-taken branch
        '{4'd5,  1'b1, 3'b111, 3'b000, 6'b100100, 1'b1, 32'h0,   3'b101, 32'h418, 32'h424, 1'b1, 1'b0}, // R5 R4 cond false
        '{4'd9,  1'b1, 3'b111, 3'b010, 6'b000000, 1'b1, 32'h900, 3'b111, 32'h424, 32'h430, 1'b1, 1'b1}, // R9 nested
        '{4'd9,  1'b1, 3'b111, 3'b000, 6'b010101, 1'b1, 32'h0,   3'b000, 32'h430, 32'h43C, 1'b1, 1'b0}, // R9 window unchanged
        '{4'd2,  1'b1, 3'b000, 3'b000, 6'b000000, 1'b0, 32'h0,   3'b000, 32'h43C, 32'h448, 1'b0, 1'b0}, // R2 no lanes
        '{4'd10, 1'b1, 3'b111, 3'b011, 6'b000000, 1'b1, 32'hA00, 3'b111, 32'h448, 32'h454, 1'b0, 1'b1}, // R10 two branches
        '{4'd6,  1'b1, 3'b111, 3'b000, 6'b111111, 1'b0, 32'h0,   3'b000, 32'h454, 32'h460, 1'b1, 1'b0}, // R6 all squashed
        '{4'd3,  1'b1, 3'b111, 3'b000, 6'b000000, 1'b0, 32'h0,   3'b111, 32'h460, 32'h46C, 1'b1, 1'b0}, // R3
        '{4'd10, 1'b1, 3'b111, 3'b000, 6'b010101, 1'b0, 32'h0,   3'b111, 32'h46C, 32'hA00, 1'b1, 1'b0}, // R10 target kept
        '{4'd11, 1'b1, 3'b101, 3'b010, 6'b000000, 1'b1, 32'hB00, 3'b101, 32'hA00, 32'hA0C, 1'b0, 1'b0}  // R11 marker on idle lane
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] lv, input logic [2:0] br,
                         input logic [5:0] g, input logic c, input logic [31:0] t);
        issue_valid = v; lane_valid = lv; lane_is_branch = br;
        lane_guard = g; branch_cond = c; branch_target = t;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3'b000, 3'b000, 6'b0, 1'b0, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(fetch_pc == 32'h100, "R1", "fetch_pc", fetch_pc, 32'h100);
        chk(!in_delay_slot, "R1", "in_delay_slot", 32'(in_delay_slot), 32'h0);
        chk(commit_en == 3'b000, "R1", "commit_en", 32'(commit_en), 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 17; k++) begin
            @(negedge clk);
            drive(VECS[k].vld, VECS[k].lv, VECS[k].br, VECS[k].grd, VECS[k].cnd, VECS[k].tgt);
            #2;
            chk(commit_en == VECS[k].x_commit, $sformatf("R%0d row %0d", VECS[k].req, k),
                "commit_en", 32'(commit_en), 32'(VECS[k].x_commit));
            chk(fetch_pc == VECS[k].x_pc, $sformatf("R%0d row %0d", VECS[k].req, k),
                "fetch_pc", fetch_pc, VECS[k].x_pc);
            chk(next_pc == VECS[k].x_npc, $sformatf("R%0d row %0d", VECS[k].req, k),
                "next_pc", next_pc, VECS[k].x_npc);
            chk(in_delay_slot == VECS[k].x_slot, $sformatf("R%0d row %0d", VECS[k].req, k),
                "in_delay_slot", 32'(in_delay_slot), 32'(VECS[k].x_slot));
            chk(nest_err == VECS[k].x_err, $sformatf("R%0d row %0d", VECS[k].req, k),
                "nest_err", 32'(nest_err), 32'(VECS[k].x_err));
        end

        // R1: reset inside an open window clears it
        @(negedge clk);
        drive(1'b1, 3'b111, 3'b001, 6'b0, 1'b1, 32'hB00);
        #2;
        chk(next_pc == 32'hA18, "R8", "next_pc", next_pc, 32'hA18);
        @(negedge clk);
        drive(1'b1, 3'b111, 3'b000, 6'b010101, 1'b0, 32'h0);
        #2;
        chk(in_delay_slot, "R7", "in_delay_slot", 32'(in_delay_slot), 32'h1);
        chk(commit_en == 3'b111, "R4", "commit_en", 32'(commit_en), 32'h7);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 3'b000, 3'b000, 6'b0, 1'b0, 32'h0);
        @(negedge clk);
        chk(fetch_pc == 32'h100, "R1", "fetch_pc mid-window", fetch_pc, 32'h100);
        chk(!in_delay_slot, "R1", "window cleared", 32'(in_delay_slot), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 3'b111, 3'b000, 6'b111111, 1'b0, 32'h0);
        #2;
        // R2 guards no longer apply after the reset
        chk(commit_en == 3'b111, "R2", "commit_en after reset", 32'(commit_en), 32'h7);
        chk(next_pc == 32'h10C, "R8", "next_pc after reset", next_pc, 32'h10C);

        // R11: branch marker with issue_valid low opens nothing
        @(negedge clk);
        drive(1'b0, 3'b111, 3'b111, 6'b0, 1'b1, 32'hC00);
        #2;
        chk(!nest_err, "R11", "nest_err idle", 32'(nest_err), 32'h0);
        @(negedge clk);
        drive(1'b1, 3'b111, 3'b000, 6'b111111, 1'b0, 32'h0);
        #2;
        chk(!in_delay_slot, "R11", "no window", 32'(in_delay_slot), 32'h0);
        chk(commit_en == 3'b111, "R11", "commit_en", 32'(commit_en), 32'h7);

        @(negedge clk);
        drive(1'b0, 3'b000, 3'b000, 6'b0, 1'b0, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule